// File: doc/BRIEF.md
# Superscalar Issue Group Former

This block sits at the head of an instruction buffer and looks at up to four decoded instructions each cycle. It decides how many of them, counted from the oldest in program order, may go to execution together as one issue group. The answer is a group size, from zero to four, and the same number is handed back to the buffer as the count of entries to pop.

Each slot presents a valid bit, a four-bit category vector, two source register numbers, a destination register number with a write enable, and a flag saying that the second source is store data. A later slot is held back if it reads a register written earlier in the group, or if it writes the same register as an earlier slot. A later write to a register that an earlier slot reads does not hold it back. There is one exception to the read rule: store data may come from the ALU instruction right before the store. The group size is worked out combinationally from the slot inputs. A registered copy of it, with a valid flag, is produced one cycle later for the issue stage.

Top module: `group_former`

## Requirements
- R1: The group size never exceeds four and counts only valid slots from slot 0 upward. An invalid slot 0 gives size 0, and the first invalid slot ends the group.
- R2: A slot whose first source, or whose second source when not flagged as store data, matches the enabled destination of an earlier slot in the candidate group ends the group before itself. This covers a shift that reads the result of the add just before it.
- R3: A slot that writes the same destination as an earlier enabled write in the candidate group ends the group before itself. A slot with its write enable low causes no such cut.
- R4: A slot writing a register that an earlier slot in the group reads does not limit the group.
- R5: A store-data source (second source, flag set) that matches the destination of the immediately preceding slot causes no cut when that slot has the integer-execution category. The category vector uses bit 0 for single-group, bit 1 for integer-execution, bit 2 for control-transfer and bit 3 for load/store. The match still cuts when the producer is further back or lacks the integer-execution bit, and the first source is never excused.
- R6: A single-group instruction (category bit 0) in slot 0 issues alone, with size 1. In any later slot it ends the group before itself.
- R7: Register 0 never creates a dependency, as a source or as a destination.
- R8: The group is a contiguous prefix. Slots after the first failing slot do not add to the size, even when they have no hazard of their own.
- R9: While stall is high the group size is 0. The pop count always equals the group size.
- R10: One cycle after each clock edge out of reset, the issue size output holds the previous cycle's group size, and the issue valid output is high exactly when that size was non-zero. A synchronous active-low reset clears both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Forces the group size to zero |
| in_vld | input | SLOTS | Per-slot valid, bit i is slot i |
| in_cat | input | SLOTS*4 | Per-slot category vector, slot i at bits 4i+3..4i |
| in_src_a | input | SLOTS*REG_W | Per-slot first source register |
| in_src_b | input | SLOTS*REG_W | Per-slot second source register |
| in_dst | input | SLOTS*REG_W | Per-slot destination register |
| in_dst_we | input | SLOTS | Per-slot destination write enable |
| in_sd_b | input | SLOTS | Per-slot flag: second source is store data |
| grp_size | output | $clog2(SLOTS+1) | Combinational group size |
| pop_cnt | output | $clog2(SLOTS+1) | Entries to pop from the buffer |
| iss_vld | output | 1 | Registered: previous group non-empty |
| iss_size | output | $clog2(SLOTS+1) | Registered previous group size |

## Verification
The bench builds the block with its default parameters: four slots and five-bit register numbers. With four slots, every hazard can be placed between adjacent slots and between slots two or three apart. This matters most for the store-data exception, which depends on adjacency. It also lets the bench put a failing slot in the middle with a clean slot after it, which tests that the group is a prefix. The 32-register space leaves room for distinct non-zero registers in every slot, alongside the register-0 cases.

// File: rtl/gf_pkg.sv
// Package: shared constants for the group former.
// Assumes category vectors are four bits wide with fixed bit meanings.
package gf_pkg;
    localparam int CAT_W      = 4;
    localparam int CAT_SINGLE = 0;
    localparam int CAT_IEU    = 1;
    localparam int CAT_CTRL   = 2;
    localparam int CAT_LDST   = 3;
endpackage

// File: rtl/gf_pair_hazard.sv
// Module: gf_pair_hazard
// Compares one earlier slot (producer) with one later slot (consumer) and
// flags whether the consumer must leave the group. Read-after-write and
// write-after-write cut the group; write-after-read is ignored. Register 0
// never matches. ADJACENT selects whether the store-data excuse may apply.
module gf_pair_hazard #(
    parameter int REG_W    = 5,
    parameter bit ADJACENT = 1'b0
) (
    input  logic             p_we,
    input  logic [REG_W-1:0] p_dst,
    input  logic             p_ieu,
    input  logic [REG_W-1:0] c_src_a,
    input  logic [REG_W-1:0] c_src_b,
    input  logic             c_sd_b,
    input  logic             c_we,
    input  logic [REG_W-1:0] c_dst,
    output logic             cut
);
    logic live_wr;
    logic raw_a;
    logic raw_b;
    logic waw;
    logic excuse_b;

    // Producer write that can create a dependency (register 0 excluded).
    assign live_wr  = p_we && (p_dst != '0);
    // Store data from the ALU slot right before may share the group.
    assign excuse_b = ADJACENT && c_sd_b && p_ieu;

    // Evaluate the three hazard kinds for this pair.
    always_comb begin
        raw_a = live_wr && (c_src_a == p_dst);
        raw_b = live_wr && (c_src_b == p_dst) && !excuse_b;
        waw   = live_wr && c_we && (c_dst == p_dst);
        cut   = raw_a || raw_b || waw;
    end
endmodule

// File: rtl/gf_slot_gate.sv
// Module: gf_slot_gate
// Decides whether one slot may join a group given the hazard cuts from all
// earlier slots. A single-group instruction is only accepted in the first
// slot, and it marks the group as closed after itself.
module gf_slot_gate #(
    parameter int SLOTS = 4,
    parameter bit FIRST = 1'b0
) (
    input  logic             vld,
    input  logic             single,
    input  logic [SLOTS-1:0] cuts,
    output logic             ok,
    output logic             close
);
    // Accept rule and close-after rule for this slot.
    always_comb begin
        if (FIRST) begin
            ok    = vld;
            close = vld && single;
        end else begin
            ok    = vld && !single && !(|cuts);
            close = 1'b0;
        end
    end
endmodule

// File: rtl/gf_prefix.sv
// Module: gf_prefix
// Turns per-slot accept flags into a contiguous prefix length. Scanning stops
// at the first rejected slot or right after a slot that closes the group.
// Stall forces a length of zero.
module gf_prefix #(
    parameter int SLOTS = 4,
    localparam int CW   = $clog2(SLOTS + 1)
) (
    input  logic [SLOTS-1:0] ok,
    input  logic [SLOTS-1:0] close,
    input  logic             stall,
    output logic [CW-1:0]    size
);
    logic stop;

    // Priority scan in program order.
    always_comb begin
        size = '0;
        stop = stall;
        for (int i = 0; i < SLOTS; i++) begin
            if (!stop) begin
                if (ok[i]) begin
                    size = CW'(i + 1);
                    if (close[i]) stop = 1'b1;
                end else begin
                    stop = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/group_former.sv
// Module: group_former
// Forms an in-order issue group of up to SLOTS instructions from the head of
// the instruction buffer. Group size is combinational; a registered copy with
// a valid flag is offered to the issue stage one cycle later.
// Assumes the buffer presents its oldest entry in slot 0.
module group_former
    import gf_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int REG_W = 5,
    localparam int CW   = $clog2(SLOTS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   stall,
    input  logic [SLOTS-1:0]       in_vld,
    input  logic [SLOTS*CAT_W-1:0] in_cat,
    input  logic [SLOTS*REG_W-1:0] in_src_a,
    input  logic [SLOTS*REG_W-1:0] in_src_b,
    input  logic [SLOTS*REG_W-1:0] in_dst,
    input  logic [SLOTS-1:0]       in_dst_we,
    input  logic [SLOTS-1:0]       in_sd_b,
    output logic [CW-1:0]          grp_size,
    output logic [CW-1:0]          pop_cnt,
    output logic                   iss_vld,
    output logic [CW-1:0]          iss_size
);
    logic [REG_W-1:0] src_a [SLOTS];
    logic [REG_W-1:0] src_b [SLOTS];
    logic [REG_W-1:0] dst   [SLOTS];
    logic [SLOTS-1:0] is_single;
    logic [SLOTS-1:0] is_ieu;
    logic [SLOTS-1:0] ok;
    logic [SLOTS-1:0] close;
    logic [CW-1:0]    size_c;

    genvar j, k;
    generate
        for (j = 0; j < SLOTS; j++) begin : g_slot
            logic [SLOTS-1:0] row;

            assign src_a[j]     = in_src_a[j*REG_W +: REG_W];
            assign src_b[j]     = in_src_b[j*REG_W +: REG_W];
            assign dst[j]       = in_dst[j*REG_W +: REG_W];
            assign is_single[j] = in_cat[j*CAT_W + CAT_SINGLE];
            assign is_ieu[j]    = in_cat[j*CAT_W + CAT_IEU];

            for (k = 0; k < SLOTS; k++) begin : g_pair
                if (k < j) begin : g_cmp
                    gf_pair_hazard #(
                        .REG_W    (REG_W),
                        .ADJACENT (k == j - 1)
                    ) u_hz (
                        .p_we    (in_dst_we[k]),
                        .p_dst   (dst[k]),
                        .p_ieu   (is_ieu[k]),
                        .c_src_a (src_a[j]),
                        .c_src_b (src_b[j]),
                        .c_sd_b  (in_sd_b[j]),
                        .c_we    (in_dst_we[j]),
                        .c_dst   (dst[j]),
                        .cut     (row[k])
                    );
                end else begin : g_none
                    assign row[k] = 1'b0;
                end
            end

            gf_slot_gate #(
                .SLOTS (SLOTS),
                .FIRST (j == 0)
            ) u_gate (
                .vld    (in_vld[j]),
                .single (is_single[j]),
                .cuts   (row),
                .ok     (ok[j]),
                .close  (close[j])
            );
        end
    endgenerate

    gf_prefix #(.SLOTS(SLOTS)) u_prefix (
        .ok    (ok),
        .close (close),
        .stall (stall),
        .size  (size_c)
    );

    assign grp_size = size_c;
    assign pop_cnt  = size_c;

    // Register the group for the issue stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_vld  <= 1'b0;
            iss_size <= '0;
        end else begin
            iss_vld  <= (size_c != '0);
            iss_size <= size_c;
        end
    end
endmodule

// File: rtl/gf_checker.sv
// Module: gf_checker
// Property checks on the group former ports, attached with bind.
module gf_checker
    import gf_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int REG_W = 5,
    localparam int CW   = $clog2(SLOTS + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   stall,
    input logic [SLOTS-1:0]       in_vld,
    input logic [SLOTS*CAT_W-1:0] in_cat,
    input logic [SLOTS*REG_W-1:0] in_src_a,
    input logic [SLOTS*REG_W-1:0] in_src_b,
    input logic [SLOTS*REG_W-1:0] in_dst,
    input logic [SLOTS-1:0]       in_dst_we,
    input logic [SLOTS-1:0]       in_sd_b,
    input logic [CW-1:0]          grp_size,
    input logic [CW-1:0]          pop_cnt,
    input logic                   iss_vld,
    input logic [CW-1:0]          iss_size
);
    logic head_pair;
    logic d0_live;

    // Two valid head slots with a plain (non single-group) first slot.
    assign head_pair = !stall && in_vld[0] && in_vld[1] && !in_cat[CAT_SINGLE];
    assign d0_live   = in_dst_we[0] && (in_dst[REG_W-1:0] != '0);

    assert_empty_head_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld[0] |-> grp_size == '0);

    assert_size_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        grp_size <= CW'(SLOTS));

    assert_raw_adjacent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (head_pair && d0_live && in_src_a[2*REG_W-1:REG_W] == in_dst[REG_W-1:0])
        |-> grp_size == CW'(1));

    assert_waw_adjacent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (head_pair && d0_live && in_dst_we[1] &&
         in_dst[2*REG_W-1:REG_W] == in_dst[REG_W-1:0])
        |-> grp_size == CW'(1));

    assert_single_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && in_vld[0] && in_cat[CAT_SINGLE]) |-> grp_size == CW'(1));

    assert_single_later_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_cat[CAT_W + CAT_SINGLE] |-> grp_size <= CW'(1));

    assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> grp_size == '0);

    assert_issue_copy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (iss_size == $past(grp_size)) &&
                         (iss_vld == ($past(grp_size) != '0)));

    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (iss_size == '0) && !iss_vld);
endmodule

bind group_former gf_checker #(.SLOTS(SLOTS), .REG_W(REG_W)) u_chk (.*);

// File: tb/sim_group_former.sv
// Bench: table-driven vectors followed by directed reset, stall and issue tests.
module sim_group_former;
    localparam int SLOTS = 4;
    localparam int REG_W = 5;
    localparam int CW    = 3;

    localparam logic [3:0] CS = 4'b0001; // single-group
    localparam logic [3:0] CI = 4'b0010; // integer-execution
    localparam logic [3:0] CC = 4'b0100; // control-transfer
    localparam logic [3:0] CL = 4'b1000; // load/store

    typedef struct packed {
        logic       v;
        logic [3:0] c;
        logic [4:0] a;
        logic [4:0] b;
        logic [4:0] d;
        logic       w;
        logic       s;
    } slot_t;

    typedef struct packed {
        slot_t      s0;
        slot_t      s1;
        slot_t      s2;
        slot_t      s3;
        logic [2:0] exp;
        logic [3:0] req;
    } vec_t;

    function automatic slot_t mk(input logic v, input logic [3:0] c,
                                 input int a, input int b, input int d,
                                 input logic w, input logic s);
        slot_t r;
        r.v = v; r.c = c; r.a = 5'(a); r.b = 5'(b); r.d = 5'(d); r.w = w; r.s = s;
        return r;
    endfunction

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        // R1: four independent slots
        '{mk(1,CI,1,2,3,1,0),   mk(1,CI,4,5,6,1,0),   mk(1,CI,7,8,9,1,0),   mk(1,CL,10,11,12,1,0), 3'd4, 4'd1},
        // R1: slot 3 invalid
        '{mk(1,CI,1,2,3,1,0),   mk(1,CI,4,5,6,1,0),   mk(1,CI,7,8,9,1,0),   mk(0,CI,1,1,1,1,0),    3'd3, 4'd1},
        // R2: slot 2 reads slot 0 result on first source
        '{mk(1,CI,1,2,3,1,0),   mk(1,CI,4,5,6,1,0),   mk(1,CI,3,7,8,1,0),   mk(1,CI,9,10,11,1,0),  3'd2, 4'd2},
        // R2: shift reads the add just before
        '{mk(1,CI,1,2,6,1,0),   mk(1,CI,6,0,8,1,0),   mk(1,CI,9,10,11,1,0), mk(1,CI,12,13,14,1,0), 3'd1, 4'd2},
        // R2: second source without store flag
        '{mk(1,CI,1,2,3,1,0),   mk(1,CI,4,3,5,1,0),   mk(1,CI,9,10,11,1,0), mk(1,CI,12,13,14,1,0), 3'd1, 4'd2},
        // R3: slot 2 rewrites slot 0 destination
        '{mk(1,CI,1,2,5,1,0),   mk(1,CI,3,4,7,1,0),   mk(1,CI,8,9,5,1,0),   mk(1,CI,10,11,12,1,0), 3'd2, 4'd3},
        // R3: same destination with write enable low, no cut
        '{mk(1,CI,1,2,5,1,0),   mk(1,CC,3,4,5,0,0),   mk(1,CI,8,9,10,1,0),  mk(1,CI,11,12,13,1,0), 3'd4, 4'd3},
        // R4: later slots write what earlier ones read
        '{mk(1,CI,3,4,9,1,0),   mk(1,CI,5,6,3,1,0),   mk(1,CI,5,7,4,1,0),   mk(1,CI,1,2,6,1,0),    3'd4, 4'd4},
        // R5: store data from the ALU slot just before
        '{mk(1,CI,1,2,6,1,0),   mk(1,CL,8,6,0,0,1),   mk(1,CI,9,10,11,1,0), mk(1,CI,12,13,14,1,0), 3'd4, 4'd5},
        // R5: store data producer two slots back
        '{mk(1,CI,1,2,6,1,0),   mk(1,CI,3,4,7,1,0),   mk(1,CL,8,6,0,0,1),   mk(1,CI,12,13,14,1,0), 3'd2, 4'd5},
        // R5: producer is a load, not integer-execution
        '{mk(1,CL,1,2,6,1,0),   mk(1,CL,8,6,0,0,1),   mk(1,CI,9,10,11,1,0), mk(1,CI,12,13,14,1,0), 3'd1, 4'd5},
        // R5: store address on first source is never excused
        '{mk(1,CI,1,2,6,1,0),   mk(1,CL,6,9,0,0,1),   mk(1,CI,9,10,11,1,0), mk(1,CI,12,13,14,1,0), 3'd1, 4'd5},
        // R6: single-group instruction at the head
        '{mk(1,CS,1,2,3,1,0),   mk(1,CI,4,5,6,1,0),   mk(1,CI,7,8,9,1,0),   mk(1,CI,10,11,12,1,0), 3'd1, 4'd6},
        // R6: single-group instruction in slot 2
        '{mk(1,CI,1,2,3,1,0),   mk(1,CI,4,5,6,1,0),   mk(1,CS,7,8,9,1,0),   mk(1,CI,10,11,12,1,0), 3'd2, 4'd6},
        // R7: register 0 as source and destination
        '{mk(1,CI,1,2,0,1,0),   mk(1,CI,0,0,0,1,0),   mk(1,CI,0,3,0,1,0),   mk(1,CI,4,0,5,1,0),    3'd4, 4'd7},
        // R8: invalid head blocks all later slots
        '{mk(0,CI,1,2,3,1,0),   mk(1,CI,4,5,6,1,0),   mk(1,CI,7,8,9,1,0),   mk(1,CI,10,11,12,1,0), 3'd0, 4'd8},
        // R8: hole in slot 1
        '{mk(1,CI,1,2,3,1,0),   mk(0,CI,4,5,6,1,0),   mk(1,CI,7,8,9,1,0),   mk(1,CI,10,11,12,1,0), 3'd1, 4'd8},
        // R8: slot 2 fails, clean slot 3 is not taken
        '{mk(1,CI,1,2,3,1,0),   mk(1,CI,4,5,6,1,0),   mk(1,CI,6,8,9,1,0),   mk(1,CI,10,11,12,1,0), 3'd2, 4'd8},
        // R1: mixed categories, control transfer last
        '{mk(1,CI|CL,1,2,3,1,0),mk(1,CL,4,5,6,1,0),   mk(1,CI,7,8,9,1,0),   mk(1,CC|CI,10,11,12,0,0), 3'd4, 4'd1}
    };

    logic             clk;
    logic             rst_n;
    logic             stall;
    vec_t             cur;
    logic [SLOTS-1:0] in_vld;
    logic [SLOTS*4-1:0] in_cat;
    logic [SLOTS*REG_W-1:0] in_src_a;
    logic [SLOTS*REG_W-1:0] in_src_b;
    logic [SLOTS*REG_W-1:0] in_dst;
    logic [SLOTS-1:0] in_dst_we;
    logic [SLOTS-1:0] in_sd_b;
    logic [CW-1:0]    grp_size;
    logic [CW-1:0]    pop_cnt;
    logic             iss_vld;
    logic [CW-1:0]    iss_size;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Flatten the current vector onto the slot buses.
    always_comb begin
        in_vld    = {cur.s3.v, cur.s2.v, cur.s1.v, cur.s0.v};
        in_cat    = {cur.s3.c, cur.s2.c, cur.s1.c, cur.s0.c};
        in_src_a  = {cur.s3.a, cur.s2.a, cur.s1.a, cur.s0.a};
        in_src_b  = {cur.s3.b, cur.s2.b, cur.s1.b, cur.s0.b};
        in_dst    = {cur.s3.d, cur.s2.d, cur.s1.d, cur.s0.d};
        in_dst_we = {cur.s3.w, cur.s2.w, cur.s1.w, cur.s0.w};
        in_sd_b   = {cur.s3.s, cur.s2.s, cur.s1.s, cur.s0.s};
    end

    group_former #(.SLOTS(SLOTS), .REG_W(REG_W)) u0 (
        .clk(clk), .rst_n(rst_n), .stall(stall),
        .in_vld(in_vld), .in_cat(in_cat), .in_src_a(in_src_a),
        .in_src_b(in_src_b), .in_dst(in_dst), .in_dst_we(in_dst_we),
        .in_sd_b(in_sd_b), .grp_size(grp_size), .pop_cnt(pop_cnt),
        .iss_vld(iss_vld), .iss_size(iss_size)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        stall = 1'b0;
        cur   = VEC[0];
        repeat (3) @(posedge clk);
        #1;
        // R10: reset clears issue outputs
        check("R10 reset iss_size", int'(iss_size), 0);
        check("R10 reset iss_vld", int'(iss_vld), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: combinational size, pop count, then registered copy.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cur = VEC[i];
            #2;
            check($sformatf("R%0d vec %0d grp_size", VEC[i].req, i), int'(grp_size), int'(VEC[i].exp));
            check($sformatf("R9 vec %0d pop_cnt", i), int'(pop_cnt), int'(VEC[i].exp));
            @(posedge clk);
            #1;
            check($sformatf("R10 vec %0d iss_size", i), int'(iss_size), int'(VEC[i].exp));
            check($sformatf("R10 vec %0d iss_vld", i), int'(iss_vld), int'(VEC[i].exp != 0));
        end

        // R9: stall with four clean slots gives zero, pop zero, no issue.
        @(negedge clk);
        cur   = VEC[0];
        stall = 1'b1;
        #2;
        check("R9 stall grp_size", int'(grp_size), 0);
        check("R9 stall pop_cnt", int'(pop_cnt), 0);
        @(posedge clk);
        #1;
        check("R10 stall iss_vld", int'(iss_vld), 0);
        @(negedge clk);
        stall = 1'b0;
        #2;
        check("R9 release grp_size", int'(grp_size), 4);

        // R10: reset in mid-run clears the issue register.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R10 midrun reset iss_size", int'(iss_size), 0);
        check("R10 midrun reset iss_vld", int'(iss_vld), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R10 after reset iss_size", int'(iss_size), 4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule